// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This execution unit serves a 32-bit processor. It takes an instruction word together with the values of the source register and the current destination register. It then forms the result of one of two immediate bit-field operations. The operation is decoded on every clock cycle, and the outputs are registered, so each result appears one cycle after its inputs.

The extract operation takes a field from the source value at a bit offset given in the instruction. It returns that field right-aligned, with zeros above it. The insert operation takes the low bits of the source value and places them into the old destination value, starting at the offset. Destination bits outside the field keep their old values.

The insert form does not encode its width directly. Instead it encodes the position of the field's top bit, and the unit recovers the width from that. An encoding that cannot be carried out raises an illegal-encoding flag.

Top module: `bitfield_xu`

## Requirements
- R1: `op_hit_o` is 1 exactly when `(insn & 32'hFC00C000)` equals `32'h64004000` (extract, bit 14 set) or `32'h64008000` (insert, bit 14 clear). Bits 13:11 and bit 5 of the word have no effect on any output.
- R2: `rd_o` carries instruction bits 25:21 for every word, whether it decodes or not.
- R3: For a legal extract with offset `insn[4:0]` and width `insn[10:6]`, the result is source bits `[off +: width]` placed at bit 0, and every bit at or above `width` is zero.
- R4: An extract whose width field is 0 produces a result of 0.
- R5: For a legal insert, result bits `off` through `insn[10:6]` take source bits 0 upward. Every other result bit equals the old destination value.
- R6: The insert width is computed as `insn[10:6] - off + 1`. A top field of 31 with offset 0 therefore replaces the whole word with the source value.
- R7: An insert whose top field is below its offset raises `bad_enc_o`, and the result equals the old destination value.
- R8: An extract whose offset plus width exceeds 32 raises `bad_enc_o`, and the result is 0.
- R9: For a word that matches neither operation, `op_hit_o` and `bad_enc_o` are 0 and the result is 0.
- R10: All outputs are registered with one cycle of latency. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_i | input | 32 | Instruction word |
| src_i | input | 32 | Source register value |
| dst_i | input | 32 | Current destination register value |
| result_o | output | 32 | Operation result |
| rd_o | output | 5 | Destination register index |
| op_hit_o | output | 1 | Word is an extract or insert |
| bad_enc_o | output | 1 | Recognised word with an illegal field encoding |

## Verification
The embedded properties compare each registered output with the inputs from the cycle before. They assume the inputs are stable and known around each rising edge, and they hold only while reset has been released for at least one cycle.

The bench drives every input half a cycle away from the sampling edge, so each property sees one well-defined input set per cycle. The stimulus sweeps every offset and field value for both operations. That sweep covers the legal and illegal encodings alike, so no property is exercised only on a narrow subset of its inputs.

// File: rtl/bitfield_xu.sv
module bitfield_xu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] insn_i,
  input  logic [31:0] src_i,
  input  logic [31:0] dst_i,
  output logic [31:0] result_o,
  output logic [4:0]  rd_o,
  output logic        op_hit_o,
  output logic        bad_enc_o
);

  localparam logic [31:0] OPC_MASK = 32'hFC00C000;
  localparam logic [31:0] OPC_EXT  = 32'h64004000;
  localparam logic [31:0] OPC_INS  = 32'h64008000;

  logic        is_ext, is_ins, ext_bad, ins_bad;
  logic [4:0]  off, fld;
  logic [5:0]  width;
  logic [32:0] mask33;
  logic [31:0] fmask, pmask, ext_val, ins_val, result_d;

  assign is_ext  = (insn_i & OPC_MASK) == OPC_EXT;
  assign is_ins  = (insn_i & OPC_MASK) == OPC_INS;
  assign off     = insn_i[4:0];
  assign fld     = insn_i[10:6];
  assign ext_bad = is_ext && (({1'b0, fld} + {1'b0, off}) > 6'd32);
  assign ins_bad = is_ins && (fld < off);
  assign width   = is_ins ? ({1'b0, fld} - {1'b0, off} + 6'd1) : {1'b0, fld};
  assign mask33  = (33'd1 << width) - 33'd1;
  assign fmask   = mask33[31:0];
  assign pmask   = fmask << off;
  assign ext_val = (src_i >> off) & fmask;
  assign ins_val = (dst_i & ~pmask) | ((src_i << off) & pmask);

  always_comb begin
    if (is_ext)      result_d = ext_bad ? 32'd0 : ext_val;
    else if (is_ins) result_d = ins_bad ? dst_i : ins_val;
    else             result_d = 32'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o  <= 32'd0;
      rd_o      <= 5'd0;
      op_hit_o  <= 1'b0;
      bad_enc_o <= 1'b0;
    end else begin
      result_o  <= result_d;
      rd_o      <= insn_i[25:21];
      op_hit_o  <= is_ext | is_ins;
      bad_enc_o <= ext_bad | ins_bad;
    end
  end

  assert_bad_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_enc_o |-> op_hit_o);

  assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_hit_o |-> (result_o == 32'd0 && !bad_enc_o));

  assert_rd_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rd_o == $past(insn_i[25:21]));

  assert_ext_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(is_ext) && !$past(ext_bad))
      |-> (({1'b0, result_o} >> $past(fld)) == 33'd0));

  assert_ins_low_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(is_ins) && !$past(ins_bad))
      |-> (((result_o ^ $past(dst_i)) & ((32'd1 << $past(off)) - 32'd1)) == 32'd0));

  assert_ins_high_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(is_ins) && !$past(ins_bad))
      |-> ((((result_o ^ $past(dst_i)) >> $past(fld)) >> 1) == 32'd0));

  assert_ins_bad_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(is_ins) && $past(fld < off))
      |-> (bad_enc_o && result_o == $past(dst_i)));

endmodule

// File: tb/bitfield_xu_bench.sv
module bitfield_xu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn_i = 32'd0, src_i = 32'd0, dst_i = 32'd0;
  logic [31:0] result_o;
  logic [4:0]  rd_o;
  logic        op_hit_o, bad_enc_o;
  int          total = 0, bad = 0;
  logic [31:0] seed = 32'h1234_5678;
  bit          done = 0;

  always #4 clk = ~clk;

  bitfield_xu u_bitfield_xu (
    .clk(clk), .rst_n(rst_n), .insn_i(insn_i), .src_i(src_i), .dst_i(dst_i),
    .result_o(result_o), .rd_o(rd_o), .op_hit_o(op_hit_o), .bad_enc_o(bad_enc_o)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic [31:0] s, input logic [31:0] d,
                     input string tag, input logic [31:0] er, input logic eh, input logic eb);
    @(negedge clk);
    insn_i = w; src_i = s; dst_i = d;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " result"}, result_o, er);
    chk("R1 hit", {31'd0, op_hit_o}, {31'd0, eh});
    chk({tag, " bad"}, {31'd0, bad_enc_o}, {31'd0, eb});
    chk("R2 rd", {27'd0, rd_o}, {27'd0, w[25:21]});
  endtask

  initial begin
    #200000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    insn_i = 32'h64004000 | (5'd7 << 21); src_i = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R10 reset result", result_o, 32'd0);
    chk("R10 reset flags", {30'd0, op_hit_o, bad_enc_o}, 32'd0);
    chk("R10 reset rd", {27'd0, rd_o}, 32'd0);
    rst_n = 1'b1;

    for (int op = 0; op < 2; op++)
      for (int f = 0; f < 32; f++)
        for (int o = 0; o < 32; o++) begin
          logic [31:0] w, s, d, er;
          logic        eb;
          string       tag;
          seed = nxt(seed); s = seed;
          seed = nxt(seed); d = seed;
          seed = nxt(seed);
          w = (op == 0 ? 32'h64004000 : 32'h64008000) | {6'd0, seed[4:0], seed[9:5], 16'd0}
              | {21'd0, seed[12:10], 11'd0} | {26'd0, seed[13], 5'd0}
              | (f[4:0] << 6) | {27'd0, o[4:0]};
          er = 32'd0;
          if (op == 0) begin
            eb = (f + o) > 32;
            tag = eb ? "R8 ext illegal" : (f == 0 ? "R4 ext width0" : "R3 ext");
            if (!eb) for (int b = 0; b < f; b++) er[b] = s[b + o];
          end else begin
            eb = f < o;
            tag = eb ? "R7 ins illegal" : ((f == 31 && o == 0) ? "R6 ins full" : "R5 ins");
            for (int b = 0; b < 32; b++)
              er[b] = (!eb && b >= o && b <= f) ? s[b - o] : d[b];
          end
          run(w, s, d, tag, er, 1'b1, eb);
        end

    run(32'h6400_0000 | 32'h3F, 32'hFFFF_FFFF, 32'hAAAA_AAAA, "R9 both clear", 32'd0, 1'b0, 1'b0);
    run(32'h6400_C0C5, 32'hFFFF_FFFF, 32'hAAAA_AAAA, "R9 both set", 32'd0, 1'b0, 1'b0);
    run(32'h6800_4085, 32'hFFFF_FFFF, 32'hAAAA_AAAA, "R9 major differs", 32'd0, 1'b0, 1'b0);
    run(32'h0000_0000 | (5'd19 << 21), 32'h1, 32'h2, "R9 zero word", 32'd0, 1'b0, 1'b0);
    run(32'h6400_87C0, 32'h1357_9BDF, 32'hFFFF_0000, "R6 whole word", 32'h1357_9BDF, 1'b1, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule